// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block sits behind an I2C bit shifter on the target side of the bus. It decides whether the first byte after a START selects this device. Four slave address slots are programmed through a small register port. Each slot has its own mask, and each slot's bit 0 allows the device to answer the all-zero general call. When the shifter marks an address byte valid, the block compares the byte against every slot at once. One clock later it reports a single-cycle match pulse, the index of the winning slot and a general-call flag.

The same block also keeps a read-only data buffer. Whenever the shifter signals that the ninth bit of a transfer (eight data bits plus the acknowledge) has gone by, the buffer takes a copy of the eight data bits the shifter presents. The pin drivers, the bit shifter itself and any controller-side logic are outside this block.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, every address and mask register reads 0x00, the data buffer is 0x00, and match_pulse, gc_pulse and match_idx are all 0.
- R2: A write with cfg_addr[2]=0 stores all 8 bits of cfg_wdata into address slot cfg_addr[1:0]. A write with cfg_addr[2]=1 stores bits 7:1 into the mask of that slot. cfg_rdata returns the addressed register combinationally, and mask bit 0 always reads as 0.
- R3: When addr_valid is high and addr_byte[7:1] equals slot bits 7:1 on every unmasked bit, match_pulse is high for exactly the next cycle and match_idx gives that slot.
- R4: A mask bit set to 1 at position k (k in 7..1) drops addr_byte bit k from the comparison for its slot only.
- R5: When several slots match, match_idx reports the lowest-numbered one.
- R6: The R/W bit addr_byte[0] plays no part in a normal address match, and a byte that matches no slot produces no pulse.
- R7: addr_byte = 0x00, with at least one slot whose bit 0 is 1, raises both gc_pulse and match_pulse for one cycle. match_idx is then the lowest slot with bit 0 set, and masks are not applied.
- R8: An all-zero address never matches through the masked comparators. With no slot's bit 0 set, or with R/W = 1 (byte 0x01), it gives no pulse at all.
- R9: match_pulse and gc_pulse only follow a cycle in which addr_valid was high; with addr_valid low no pulse appears.
- R10: The data buffer loads shift_data on a cycle with ninth_strobe high, becomes visible the next cycle, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Bit 2 selects mask bank, bits 1:0 select the slot |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| addr_valid | input | 1 | Marks addr_byte as the first byte after START |
| addr_byte | input | 8 | Received address in bits 7:1, R/W in bit 0 |
| ninth_strobe | input | 1 | One-cycle mark after the ninth bit of a byte |
| shift_data | input | 8 | Data bits held by the shifter |
| match_pulse | output | 1 | One-cycle pulse: this device is selected |
| match_idx | output | 2 | Slot that selected the device |
| gc_pulse | output | 1 | One-cycle pulse: general call accepted |
| buf_data | output | 8 | Data buffer |

## Verification
The bench goes after overlapping slots. If the priority encoder were built in the wrong direction, a byte accepted by slots 0 and 2 would come back with index 2. It checks a byte that differs only in masked bits: a mask applied to the wrong slot or shifted by one bit would drop that match. It sends the all-zero address to a slot programmed as address 0 with a full mask, and to a configuration with the general-call enables cleared. Letting masks reach the general-call path, or ignoring the enable bits, would raise a false pulse in either case. It also toggles shift_data without a strobe, so that a buffer loading on every cycle shows up.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 7;

  typedef enum logic {
    BANK_ADDR = 1'b0,
    BANK_MASK = 1'b1
  } am_bank_e;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/i2c_am_regfile.sv
module i2c_am_regfile
  import i2c_addr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CA_W  = IDX_W + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [CA_W-1:0]                   addr,
  input  byte_t                             wdata,
  output byte_t                             rdata,
  output logic [NUM_SLOTS-1:0][BYTE_W-1:0]  slot_addr,
  output logic [NUM_SLOTS-1:0][ADR_W-1:0]   slot_mask
);
  am_bank_e         bank;
  logic [IDX_W-1:0] sel;

  assign bank = am_bank_e'(addr[IDX_W]);
  assign sel  = addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    byte_t            adr_q, adr_d;
    logic [ADR_W-1:0] msk_q, msk_d;
    logic             adr_en, msk_en;

    assign adr_en = we && (bank == BANK_ADDR) && (sel == IDX_W'(g));
    assign msk_en = we && (bank == BANK_MASK) && (sel == IDX_W'(g));

    always_comb begin
      adr_d = adr_q;
      msk_d = msk_q;
      if (adr_en) adr_d = wdata;
      if (msk_en) msk_d = wdata[BYTE_W-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        adr_q <= '0;
        msk_q <= '0;
      end else begin
        adr_q <= adr_d;
        msk_q <= msk_d;
      end
    end

    assign slot_addr[g] = adr_q;
    assign slot_mask[g] = msk_q;
  end

  always_comb begin
    if (bank == BANK_MASK) rdata = {slot_mask[sel], 1'b0};
    else                   rdata = slot_addr[sel];
  end
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_addr_pkg::*;
(
  input  byte_t            rx_byte,
  input  byte_t            slot_addr,
  input  logic [ADR_W-1:0] slot_mask,
  output logic             hit,
  output logic             gc_hit
);
  logic             zero_adr;
  logic [ADR_W-1:0] diff;

  assign zero_adr = (rx_byte[BYTE_W-1:1] == '0);
  assign diff     = (rx_byte[BYTE_W-1:1] ^ slot_addr[BYTE_W-1:1]) & ~slot_mask;
  assign hit      = !zero_adr && (diff == '0);
  assign gc_hit   = zero_adr && !rx_byte[0] && slot_addr[0];
endmodule

// File: rtl/i2c_am_prio.sv
module i2c_am_prio #(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] hits,
  input  logic [NUM_SLOTS-1:0] gc_hits,
  output logic                 any,
  output logic                 any_gc,
  output logic [IDX_W-1:0]     idx
);
  logic [NUM_SLOTS-1:0] sel;

  assign any_gc = |gc_hits;
  assign sel    = any_gc ? gc_hits : hits;
  assign any    = |sel;

  always_comb begin
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (sel[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/i2c_am_buf.sv
module i2c_am_buf
  import i2c_addr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t din,
  output byte_t dout
);
  byte_t buf_q, buf_d;

  always_comb begin
    buf_d = buf_q;
    if (load) buf_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  assign dout = buf_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CA_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              addr_valid,
  input  logic [7:0]        addr_byte,
  input  logic              ninth_strobe,
  input  logic [7:0]        shift_data,
  output logic              match_pulse,
  output logic [IDX_W-1:0]  match_idx,
  output logic              gc_pulse,
  output logic [7:0]        buf_data
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SLOTS-1:0][BYTE_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][ADR_W-1:0]  slot_mask;
  logic [NUM_SLOTS-1:0]             hits, gc_hits;
  logic                             any, any_gc;
  logic [IDX_W-1:0]                 win_idx;

  i2c_am_regfile #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .slot_addr (slot_addr),
    .slot_mask (slot_mask)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    i2c_am_cmp u_cmp (
      .rx_byte   (addr_byte),
      .slot_addr (slot_addr[g]),
      .slot_mask (slot_mask[g]),
      .hit       (hits[g]),
      .gc_hit    (gc_hits[g])
    );
  end

  i2c_am_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
    .hits    (hits),
    .gc_hits (gc_hits),
    .any     (any),
    .any_gc  (any_gc),
    .idx     (win_idx)
  );

  logic             match_q, match_d;
  logic             gc_q, gc_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = addr_valid && any;

  always_comb begin
    match_d = addr_valid && any;
    gc_d    = addr_valid && any_gc;
    idx_d   = idx_q;
    if (idx_en) idx_d = win_idx;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      match_q <= 1'b0;
      gc_q    <= 1'b0;
      idx_q   <= '0;
    end else begin
      match_q <= match_d;
      gc_q    <= gc_d;
      idx_q   <= idx_d;
    end
  end

  assign match_pulse = match_q;
  assign gc_pulse    = gc_q;
  assign match_idx   = idx_q;

  i2c_am_buf u_buf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (ninth_strobe),
    .din   (shift_data),
    .dout  (buf_data)
  );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_valid,
  input logic [7:0] addr_byte,
  input logic       ninth_strobe,
  input logic [7:0] shift_data,
  input logic       match_pulse,
  input logic       gc_pulse,
  input logic [7:0] buf_data
);
  // R9
  pulse_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(addr_valid));

  // R7
  gc_with_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_pulse |-> match_pulse);

  // R7
  gc_zero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_pulse |-> ($past(addr_byte) == 8'h00));

  // R10
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ninth_strobe) |-> $stable(buf_data));

  // R10
  buf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ninth_strobe) |-> (buf_data == $past(shift_data)));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_valid   (addr_valid),
  .addr_byte    (addr_byte),
  .ninth_strobe (ninth_strobe),
  .shift_data   (shift_data),
  .match_pulse  (match_pulse),
  .gc_pulse     (gc_pulse),
  .buf_data     (buf_data)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       addr_valid;
  logic [7:0] addr_byte;
  logic       ninth_strobe;
  logic [7:0] shift_data;
  logic       match_pulse;
  logic [1:0] match_idx;
  logic       gc_pulse;
  logic [7:0] buf_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit mon_on = 0;
  logic valid_seen;

  int    exp_q[$];
  string req_q[$];

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_valid(addr_valid),
    .addr_byte(addr_byte), .ninth_strobe(ninth_strobe), .shift_data(shift_data),
    .match_pulse(match_pulse), .match_idx(match_idx), .gc_pulse(gc_pulse),
    .buf_data(buf_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // monitor: scoreboard of address decisions
  always @(posedge clk) valid_seen <= addr_valid;

  always @(negedge clk) begin
    if (mon_on) begin
      if (valid_seen) begin
        int e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(match_pulse == e[8], r, int'(match_pulse), e[8]);
        chk(gc_pulse == e[4], r, int'(gc_pulse), e[4]);
        if (e[8]) chk(match_idx == 2'(e[1:0]), r, int'(match_idx), e[1:0]);
      end else begin
        // R9: no pulse without a valid byte
        chk(!match_pulse && !gc_pulse, "R9", int'({match_pulse, gc_pulse}), 0);
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit m, input int idx, input bit gc, input string req);
    exp_q.push_back((int'(m) << 8) | (int'(gc) << 4) | idx);
    req_q.push_back(req);
    @(negedge clk);
    addr_valid = 1'b1;
    addr_byte  = b;
    @(negedge clk);
    addr_valid = 1'b0;
    addr_byte  = 8'h00;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, int'(cfg_rdata), int'(exp));
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    addr_valid = 1'b0; addr_byte = '0; ninth_strobe = 1'b0; shift_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) rd_chk(3'(i), 8'h00, "R1");
    chk(buf_data == 8'h00, "R1", int'(buf_data), 0);
    chk(!match_pulse && !gc_pulse && match_idx == 2'd0, "R1",
        int'({match_pulse, gc_pulse, match_idx}), 0);
    mon_on = 1'b1;

    // R2: programming and readback
    wr(3'd0, 8'h50);
    wr(3'd1, 8'hA1);
    wr(3'd2, 8'h50);
    wr(3'd3, 8'h3D);
    wr(3'd7, 8'h07);
    rd_chk(3'd1, 8'hA1, "R2");
    rd_chk(3'd3, 8'h3D, "R2");
    rd_chk(3'd7, 8'h06, "R2");
    rd_chk(3'd4, 8'h00, "R2");

    send(8'h50, 1, 0, 0, "R5");   // slots 0 and 2 both accept
    send(8'h51, 1, 0, 0, "R6");   // R/W = 1 ignored
    send(8'hA0, 1, 1, 0, "R3");
    send(8'h38, 1, 3, 0, "R4");   // address 0x1C, low two bits masked
    send(8'h3F, 1, 3, 0, "R4");   // address 0x1F
    send(8'h40, 0, 0, 0, "R6");   // address 0x20, bit 2 not masked
    send(8'h00, 1, 1, 1, "R7");   // slots 1 and 3 enabled, lowest is 1
    send(8'h01, 0, 0, 0, "R8");   // general call with R/W = 1

    // R8: enables cleared, slot 0 set to address 0 with a full mask
    wr(3'd1, 8'hA0);
    wr(3'd3, 8'h3C);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'hFE);
    send(8'h00, 0, 0, 0, "R8");
    send(8'h12, 1, 0, 0, "R4");   // full mask accepts any nonzero address

    // R9: address byte present without valid
    @(negedge clk);
    addr_byte = 8'hA0;
    repeat (3) @(negedge clk);
    addr_byte = 8'h00;

    // R10: data buffer
    @(negedge clk);
    shift_data = 8'hC3; ninth_strobe = 1'b1;
    @(negedge clk);
    ninth_strobe = 1'b0; shift_data = 8'h5A;
    chk(buf_data == 8'hC3, "R10", int'(buf_data), 8'hC3);
    repeat (3) @(negedge clk);
    chk(buf_data == 8'hC3, "R10", int'(buf_data), 8'hC3);
    ninth_strobe = 1'b1;
    @(negedge clk);
    ninth_strobe = 1'b0;
    chk(buf_data == 8'h5A, "R10", int'(buf_data), 8'h5A);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule